// File: doc/BRIEF.md
# Serial Control-Register Write Port

This block accepts register writes from a three-wire serial port (a serial clock, a serial data line and an active-low select) and keeps three write-only control registers. The serial lines are synchronized into the system clock domain. Each rising serial-clock edge taken while the select is low shifts in one bit. A 32-bit frame starts with a fixed 12-bit header, continues with a 4-bit register address and ends with a 16-bit value. A frame that completes commits its value to the addressed register and raises a one-cycle write strobe.

The port is active only while the extended-control enable input is high. The configuration register's four mode bits and the two 9-bit adjust fields are driven as parallel outputs. Two status outputs are also provided. One reports that every register has been written at least once since reset. The other reports that the configuration register holds an illegal pairing: double-rate output selected together with the output-edge bit set. Frames may follow each other with the select held low, and a new frame begins on the 33rd serial-clock edge.

Top module: `ser_reg_slave`

## Requirements
- R1: A frame is 32 bits, most significant bit first. Bits 31:20 are the header, bits 19:16 are the address and bits 15:0 are the data. The header must equal 12'h001, so eleven 0 bits are sent first and then a single 1.
- R2: A bit is taken on each rising edge of `sclk` while `scs_n` is low. All three serial inputs pass through a two-stage synchronizer, so `sclk` must stay high, and stay low, for at least four `clk` periods.
- R3: After the 32nd bit of a frame, the next rising `sclk` edge is the first bit of a new frame. `scs_n` does not need to be released between frames.
- R4: If the 12 header bits do not equal 12'h001, the block ignores every further bit until `scs_n` has gone high.
- R5: Taking `scs_n` high before the 32nd bit discards the partial frame. The next frame is then counted from its first bit.
- R6: While `ext_ctrl_en` is low, serial bits are ignored. No register or output changes.
- R7: Address 4'h1 loads the configuration register. Its data bit 8 drives `cfg_out_edge`, bit 9 drives `cfg_low_swing`, bit 10 drives `cfg_ddr_off` and bit 11 drives `cfg_ddr_phase`. Address 4'h2 loads `offset_adj` from data bits 15:7, and address 4'h3 loads `fs_adj` from data bits 15:7. A frame with any other address changes nothing and raises no strobe.
- R8: After reset, all four configuration outputs are 0, which selects double-rate clocking, 0° phase and normal swing. `offset_adj` is 0 and `fs_adj` is 9'h100, the nominal midpoint. `all_written`, `ddr_edge_err` and `wr_stb` are 0.
- R9: A write to 4'h1 with data bit 10 = 0 and data bit 8 = 1 sets `ddr_edge_err`. Any other write to 4'h1 clears it. Writes to other addresses leave it unchanged.
- R10: `all_written` rises only once each of 4'h1, 4'h2 and 4'h3 has been committed since reset. It then stays high.
- R11: Each committed write raises `wr_stb` for exactly one `clk` cycle, and `wr_addr` carries the committed address in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_ctrl_en | input | 1 | Enables the serial port when high |
| sclk | input | 1 | Serial clock |
| sdata | input | 1 | Serial data, MSB first |
| scs_n | input | 1 | Active-low serial select |
| cfg_out_edge | output | 1 | Output-edge select (config bit 8) |
| cfg_low_swing | output | 1 | Output-amplitude select (config bit 9) |
| cfg_ddr_off | output | 1 | Double-rate disable (config bit 10) |
| cfg_ddr_phase | output | 1 | Double-rate clock phase (config bit 11) |
| offset_adj | output | 9 | Offset adjust field |
| fs_adj | output | 9 | Full-scale adjust field |
| all_written | output | 1 | All three registers written since reset |
| ddr_edge_err | output | 1 | Illegal edge bit with double-rate mode |
| wr_stb | output | 1 | One-cycle commit strobe |
| wr_addr | output | 4 | Address of the last commit |

## Verification
The bench sends a frame with a bad header and then holds the select low for a second, valid frame. A design that re-armed without waiting for the select to be released would commit that second frame. Another test cuts a frame short after 20 bits and then sends a full frame. A design that kept its bit count across the select release would take a misaligned frame and load the wrong configuration. Three frames are also sent back to back with the select held low; an off-by-one count would lose or shift the second and third frames. Further tests cover the error flag's set, hold and clear cases, the order in which `all_written` rises, writes to an unused address, and traffic while the port is disabled. Each of these should leave the outputs untouched.

// File: rtl/ser_reg_pkg.sv
package ser_reg_pkg;
  localparam int FRAME_BITS = 32;
  localparam int HDR_BITS   = 12;
  localparam int ADDR_W     = 4;
  localparam int DATA_W     = 16;
  localparam int ADJ_W      = 9;
  localparam int ADJ_LSB    = 7;
  localparam int NUM_REGS   = 3;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  localparam logic [HDR_BITS-1:0] HDR_PATTERN = 12'h001;

  localparam logic [ADDR_W-1:0] ADDR_CFG = 4'h1;
  localparam logic [ADDR_W-1:0] ADDR_OFS = 4'h2;
  localparam logic [ADDR_W-1:0] ADDR_FS  = 4'h3;

  // config data bit positions
  localparam int CFG_EDGE_BIT  = 8;
  localparam int CFG_SWING_BIT = 9;
  localparam int CFG_DDROFF_BIT = 10;
  localparam int CFG_PHASE_BIT = 11;

  typedef struct packed {
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;
endpackage

// File: rtl/ser_sync_edge.sv
module ser_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic sdata,
  input  logic scs_n,
  output logic sclk_rise,
  output logic sdata_s,
  output logic scs_n_s
);
  // vector order: {scs_n, sdata, sclk}
  localparam logic [2:0] RST_VAL = 3'b100;

  logic [2:0] stg_q [STAGES];
  logic       sclk_prev_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= {scs_n, sdata, sclk};
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[g] <= RST_VAL;
          else        stg_q[g] <= stg_q[g-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= stg_q[STAGES-1][0];
  end

  assign sclk_rise = stg_q[STAGES-1][0] & ~sclk_prev_q;
  assign sdata_s   = stg_q[STAGES-1][1];
  assign scs_n_s   = stg_q[STAGES-1][2];

  a_r2_rise_single: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_rise |=> !sclk_rise);
endmodule

// File: rtl/ser_frame_rx.sv
module ser_frame_rx
  import ser_reg_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   en,
  input  logic   bit_stb,
  input  logic   bit_val,
  input  logic   sel_n,
  output logic   frame_vld,
  output frame_t frame
);
  logic [CNT_W-1:0]      cnt_q, cnt_d;
  logic [FRAME_BITS-1:0] shift_q, shift_d;
  logic                  skip_q, skip_d;
  logic                  vld_q, vld_d;
  logic [HDR_BITS-1:0]   hdr_now;

  assign hdr_now = {shift_q[HDR_BITS-2:0], bit_val};

  always_comb begin
    cnt_d   = cnt_q;
    shift_d = shift_q;
    skip_d  = skip_q;
    vld_d   = 1'b0;
    if (sel_n) begin
      cnt_d  = '0;
      skip_d = 1'b0;
    end else if (!en) begin
      cnt_d = '0;
    end else if (bit_stb && !skip_q) begin
      shift_d = {shift_q[FRAME_BITS-2:0], bit_val};
      if (cnt_q == CNT_W'(HDR_BITS-1) && hdr_now != HDR_PATTERN) begin
        skip_d = 1'b1;
        cnt_d  = '0;
      end else if (cnt_q == CNT_W'(FRAME_BITS-1)) begin
        cnt_d = '0;
        vld_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      shift_q <= '0;
      skip_q  <= 1'b0;
      vld_q   <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      shift_q <= shift_d;
      skip_q  <= skip_d;
      vld_q   <= vld_d;
    end
  end

  assign frame_vld  = vld_q;
  assign frame.addr = shift_q[DATA_W +: ADDR_W];
  assign frame.data = shift_q[DATA_W-1:0];

  a_r1_frame_len: assert property (@(posedge clk) disable iff (!rst_n)
    frame_vld |-> $past(cnt_q) == CNT_W'(FRAME_BITS-1));
  a_r5_sel_released_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> !frame_vld);
  a_r6_disabled_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !frame_vld);
  a_r4_skip_no_frame: assert property (@(posedge clk) disable iff (!rst_n)
    skip_q |=> !frame_vld);
endmodule

// File: rtl/ser_reg_bank.sv
module ser_reg_bank
  import ser_reg_pkg::*;
#(
  parameter logic [ADJ_W-1:0] FS_RESET = 9'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_vld,
  input  frame_t            frame,
  output logic [3:0]        cfg_bits,
  output logic [ADJ_W-1:0]  offset_adj,
  output logic [ADJ_W-1:0]  fs_adj,
  output logic              all_written,
  output logic              ddr_edge_err,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr
);
  localparam logic [ADDR_W-1:0] REG_ADDR [NUM_REGS] = '{ADDR_CFG, ADDR_OFS, ADDR_FS};

  logic [NUM_REGS-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_REGS; g++) begin : g_hit
      assign hit[g] = frame_vld && (frame.addr == REG_ADDR[g]);
    end
  endgenerate

  logic [3:0]          cfg_q, cfg_d;
  logic [ADJ_W-1:0]    ofs_q, ofs_d;
  logic [ADJ_W-1:0]    fs_q, fs_d;
  logic [NUM_REGS-1:0] seen_q, seen_d;
  logic                err_q, err_d;
  logic                stb_q, stb_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;

  always_comb begin
    cfg_d  = cfg_q;
    ofs_d  = ofs_q;
    fs_d   = fs_q;
    err_d  = err_q;
    addr_d = addr_q;
    seen_d = seen_q | hit;
    stb_d  = |hit;
    if (hit[0]) begin
      cfg_d = frame.data[CFG_PHASE_BIT:CFG_EDGE_BIT];
      err_d = frame.data[CFG_EDGE_BIT] & ~frame.data[CFG_DDROFF_BIT];
    end
    if (hit[1]) ofs_d = frame.data[ADJ_LSB +: ADJ_W];
    if (hit[2]) fs_d  = frame.data[ADJ_LSB +: ADJ_W];
    if (|hit)   addr_d = frame.addr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      ofs_q  <= '0;
      fs_q   <= FS_RESET;
      seen_q <= '0;
      err_q  <= 1'b0;
      stb_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      cfg_q  <= cfg_d;
      ofs_q  <= ofs_d;
      fs_q   <= fs_d;
      seen_q <= seen_d;
      err_q  <= err_d;
      stb_q  <= stb_d;
      addr_q <= addr_d;
    end
  end

  assign cfg_bits     = cfg_q;
  assign offset_adj   = ofs_q;
  assign fs_adj       = fs_q;
  assign all_written  = &seen_q;
  assign ddr_edge_err = err_q;
  assign wr_stb       = stb_q;
  assign wr_addr      = addr_q;

  a_r11_stb_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  a_r7_stb_addr_legal: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> (wr_addr == ADDR_CFG || wr_addr == ADDR_OFS || wr_addr == ADDR_FS));
  a_r10_written_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    all_written |=> all_written);
  a_r9_err_changes_on_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ddr_edge_err) |-> (wr_stb && wr_addr == ADDR_CFG));
  a_r7_offset_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(offset_adj) |-> (wr_stb && wr_addr == ADDR_OFS));
  a_r7_fs_changes_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fs_adj) |-> (wr_stb && wr_addr == ADDR_FS));
endmodule

// File: rtl/ser_reg_slave.sv
module ser_reg_slave
  import ser_reg_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [ADJ_W-1:0]  FS_RESET    = 9'h100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ext_ctrl_en,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              scs_n,
  output logic              cfg_out_edge,
  output logic              cfg_low_swing,
  output logic              cfg_ddr_off,
  output logic              cfg_ddr_phase,
  output logic [ADJ_W-1:0]  offset_adj,
  output logic [ADJ_W-1:0]  fs_adj,
  output logic              all_written,
  output logic              ddr_edge_err,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr
);
  logic   sclk_rise, sdata_s, scs_n_s;
  logic   frame_vld;
  frame_t frame;
  logic [3:0] cfg_bits;

  ser_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk      (sclk),
    .sdata     (sdata),
    .scs_n     (scs_n),
    .sclk_rise (sclk_rise),
    .sdata_s   (sdata_s),
    .scs_n_s   (scs_n_s)
  );

  ser_frame_rx u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (ext_ctrl_en),
    .bit_stb   (sclk_rise),
    .bit_val   (sdata_s),
    .sel_n     (scs_n_s),
    .frame_vld (frame_vld),
    .frame     (frame)
  );

  ser_reg_bank #(.FS_RESET(FS_RESET)) u_bank (
    .clk          (clk),
    .rst_n        (rst_n),
    .frame_vld    (frame_vld),
    .frame        (frame),
    .cfg_bits     (cfg_bits),
    .offset_adj   (offset_adj),
    .fs_adj       (fs_adj),
    .all_written  (all_written),
    .ddr_edge_err (ddr_edge_err),
    .wr_stb       (wr_stb),
    .wr_addr      (wr_addr)
  );

  assign cfg_out_edge  = cfg_bits[0];
  assign cfg_low_swing = cfg_bits[1];
  assign cfg_ddr_off   = cfg_bits[2];
  assign cfg_ddr_phase = cfg_bits[3];

  a_r9_err_matches_cfg: assert property (@(posedge clk) disable iff (!rst_n)
    ddr_edge_err |-> (cfg_out_edge && !cfg_ddr_off));
endmodule

// File: tb/test_ser_reg_slave.sv
`timescale 1ns/1ps
module test_ser_reg_slave;
  logic clk = 1'b0;
  logic rst_n, ext_ctrl_en, sclk, sdata, scs_n;
  logic cfg_out_edge, cfg_low_swing, cfg_ddr_off, cfg_ddr_phase;
  logic [8:0] offset_adj, fs_adj;
  logic all_written, ddr_edge_err, wr_stb;
  logic [3:0] wr_addr;

  int n_cmp = 0;
  int n_bad = 0;
  int stb_cnt = 0;
  logic [3:0] last_addr = '0;

  always #4 clk = ~clk;

  ser_reg_slave i_ser_reg_slave (
    .clk(clk), .rst_n(rst_n), .ext_ctrl_en(ext_ctrl_en),
    .sclk(sclk), .sdata(sdata), .scs_n(scs_n),
    .cfg_out_edge(cfg_out_edge), .cfg_low_swing(cfg_low_swing),
    .cfg_ddr_off(cfg_ddr_off), .cfg_ddr_phase(cfg_ddr_phase),
    .offset_adj(offset_adj), .fs_adj(fs_adj),
    .all_written(all_written), .ddr_edge_err(ddr_edge_err),
    .wr_stb(wr_stb), .wr_addr(wr_addr)
  );

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin
      stb_cnt   <= stb_cnt + 1;
      last_addr <= wr_addr;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    sdata = b;
    wait_clk(4);
    sclk = 1'b1;
    wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send_bits(input logic [31:0] w, input int n);
    for (int i = 31; i > 31 - n; i--) send_bit(w[i]);
  endtask

  task automatic sel_low;
    scs_n = 1'b0;
    wait_clk(4);
  endtask

  task automatic sel_high;
    wait_clk(4);
    scs_n = 1'b1;
    wait_clk(12);
  endtask

  task automatic frame_write(input logic [3:0] a, input logic [15:0] d);
    sel_low();
    send_bits({12'h001, a, d}, 32);
    sel_high();
  endtask

  task automatic t_reset;
    chk("R8 edge", cfg_out_edge, 0);
    chk("R8 swing", cfg_low_swing, 0);
    chk("R8 ddr_off", cfg_ddr_off, 0);
    chk("R8 phase", cfg_ddr_phase, 0);
    chk("R8 offset", offset_adj, 0);
    chk("R8 fs", fs_adj, 9'h100);
    chk("R8 all_written", all_written, 0);
    chk("R8 err", ddr_edge_err, 0);
    chk("R8 stb", wr_stb, 0);
  endtask

  task automatic t_disabled;
    ext_ctrl_en = 1'b0;
    frame_write(4'h2, 16'hFF80);
    chk("R6 offset unchanged", offset_adj, 0);
    chk("R6 no strobe", stb_cnt, 0);
    ext_ctrl_en = 1'b1;
    wait_clk(4);
  endtask

  task automatic t_single;
    frame_write(4'h2, {9'h1A5, 7'h7F});
    chk("R7 offset", offset_adj, 9'h1A5);
    chk("R1 R2 fs untouched", fs_adj, 9'h100);
    chk("R11 strobe count", stb_cnt, 1);
    chk("R11 strobe addr", last_addr, 4'h2);
    chk("R10 not yet", all_written, 0);
  endtask

  task automatic t_bad_addr;
    frame_write(4'h5, 16'hFFFF);
    chk("R7 bad addr no strobe", stb_cnt, 1);
    chk("R7 bad addr offset", offset_adj, 9'h1A5);
    chk("R7 bad addr fs", fs_adj, 9'h100);
    chk("R7 bad addr cfg", {cfg_ddr_phase, cfg_ddr_off, cfg_low_swing, cfg_out_edge}, 0);
  endtask

  task automatic t_bad_header;
    sel_low();
    send_bits({12'h003, 4'h3, 16'hFF80}, 32);
    send_bits({12'h001, 4'h3, 16'hFF80}, 32);
    sel_high();
    chk("R4 fs unchanged", fs_adj, 9'h100);
    chk("R4 no strobe", stb_cnt, 1);
    frame_write(4'h3, {9'h0AA, 7'h00});
    chk("R4 rearm after release", fs_adj, 9'h0AA);
    chk("R10 still low", all_written, 0);
  endtask

  task automatic t_partial;
    sel_low();
    send_bits({12'h001, 4'h3, 16'hFFFF}, 20);
    sel_high();
    chk("R5 partial no strobe", stb_cnt, 2);
    frame_write(4'h1, 16'h0400);
    chk("R5 aligned ddr_off", cfg_ddr_off, 1);
    chk("R5 fs untouched", fs_adj, 9'h0AA);
    chk("R10 all written", all_written, 1);
    chk("R11 addr cfg", last_addr, 4'h1);
  endtask

  task automatic t_burst;
    int base;
    base = stb_cnt;
    sel_low();
    send_bits({12'h001, 4'h1, 16'h0A00}, 32);
    send_bits({12'h001, 4'h2, {9'h0C3, 7'h00}}, 32);
    send_bits({12'h001, 4'h3, {9'h155, 7'h55}}, 32);
    sel_high();
    chk("R3 strobes", stb_cnt, base + 3);
    chk("R3 cfg", {cfg_ddr_phase, cfg_ddr_off, cfg_low_swing, cfg_out_edge}, 4'b1010);
    chk("R3 offset", offset_adj, 9'h0C3);
    chk("R3 fs", fs_adj, 9'h155);
    chk("R10 sticky", all_written, 1);
  endtask

  task automatic t_cfg_err;
    frame_write(4'h1, 16'h0F00);
    chk("R7 all cfg bits", {cfg_ddr_phase, cfg_ddr_off, cfg_low_swing, cfg_out_edge}, 4'b1111);
    chk("R9 legal no err", ddr_edge_err, 0);
    frame_write(4'h1, 16'h0100);
    chk("R9 err set", ddr_edge_err, 1);
    chk("R7 edge only", {cfg_ddr_phase, cfg_ddr_off, cfg_low_swing, cfg_out_edge}, 4'b0001);
    frame_write(4'h2, 16'h0000);
    chk("R9 err held", ddr_edge_err, 1);
    frame_write(4'h1, 16'h0000);
    chk("R9 err cleared", ddr_edge_err, 0);
  endtask

  initial begin
    rst_n = 1'b0; ext_ctrl_en = 1'b1;
    sclk = 1'b0; sdata = 1'b0; scs_n = 1'b1;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    t_disabled();
    t_single();
    t_bad_addr();
    t_bad_header();
    t_partial();
    t_burst();
    t_cfg_err();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule